// File: doc/BRIEF.md
# Banked Extended RAM Burst Port

This block puts a large byte-wide RAM behind a small 7-bit register space. The RAM cannot be addressed directly: the host first sets a bank-select bit in a control register to expose the upper bank, then loads a RAM pointer through two pointer registers (low and high byte), and then moves data one byte at a time through a single data-port register. The data port always accesses the byte the pointer currently names.

A burst-enable bit in an extension register makes every data-port access, read or write, advance the pointer by one afterwards. A host can then stream a block of bytes with repeated accesses to the same offset. The pointer is as wide as the RAM depth needs, and it wraps from the last byte back to byte zero. The RAM depth is a parameter (128, 2048, 4096 or 8192 bytes), and the RAM model in the block is synthesizable.

Top module: `xram_window`

## Requirements
- R1: After synchronous reset, `rd_data` is 0x00, bank select and burst enable are clear, and the pointer is 0. Every register reads back 0x00.
- R2: The control register at offset 0x0A is visible in both banks. Its bit 4 is the bank select and reads back as written. All its other bits read 0.
- R3: While bank select is 0, every offset from 0x40 to 0x7F reads 0x00, and writes to those offsets change no state.
- R4: In the upper bank, offset 0x50 holds pointer bits 7:0 and offset 0x51 holds pointer bits 15:8. Pointer bits at or above log2(DEPTH) are discarded on write and read back as 0.
- R5: In the upper bank, a write to offset 0x53 stores the byte at the pointer address, and a read of 0x53 returns that byte. Every read returns its data on `rd_data` one cycle after the request. `rd_data` holds its value during writes and idle cycles.
- R6: Bit 5 of the extension register at offset 0x4A is the burst enable, and all its other bits read 0. While burst enable is set, each data-port read or write increments the pointer after the access, so back-to-back reads return consecutive bytes. The pointer registers read back the incremented value.
- R7: While burst enable is clear, data-port accesses leave the pointer unchanged.
- R8: The pointer increment wraps from DEPTH-1 to 0.
- R9: Offsets that map to no register read 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Register access strobe for this cycle |
| wr_en | input | 1 | 1 = write access, 0 = read access |
| reg_addr | input | 7 | Register offset |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid one cycle after a read request |

## Verification
The bench builds two copies of the block. One uses DEPTH=128 and the other DEPTH=2048. The 128-byte copy is small enough that every RAM location is written and read back with a pattern computed in the bench, so the sweep covers the whole address space, the pointer masking above bit 6 and the wrap at 0x7F in a short run. The 2048-byte copy brings the high pointer byte into play: masking to 3 bits, a carry from bit 7 into bit 8 during a burst, a wrap from 0x7FF, and checks that locations 0x000 and 0x100 are kept apart.

// File: rtl/xram_pkg.sv
package xram_pkg;

    localparam int unsigned REG_AW   = 7;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned PTR_MAXW = 16;

    localparam logic [REG_AW-1:0] OFS_CTRL   = 7'h0A;
    localparam logic [REG_AW-1:0] OFS_EXT    = 7'h4A;
    localparam logic [REG_AW-1:0] OFS_PTR_LO = 7'h50;
    localparam logic [REG_AW-1:0] OFS_PTR_HI = 7'h51;
    localparam logic [REG_AW-1:0] OFS_PORT   = 7'h53;
    localparam logic [REG_AW-1:0] UPPER_BASE = 7'h40;

    localparam int unsigned BANK_BIT  = 4;
    localparam int unsigned BURST_BIT = 5;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_CTRL,
        TGT_EXT,
        TGT_PTR_LO,
        TGT_PTR_HI,
        TGT_PORT
    } target_e;

    typedef struct packed {
        logic    rd;
        logic    wr;
        target_e tgt;
    } access_t;

    function automatic bit depth_ok(input int unsigned d);
        return (d == 128) || (d == 2048) || (d == 4096) || (d == 8192);
    endfunction

    function automatic access_t decode_access(
        input logic              strobe,
        input logic              write,
        input logic [REG_AW-1:0] ofs,
        input logic              upper
    );
        access_t a;
        a.rd  = strobe && !write;
        a.wr  = strobe && write;
        a.tgt = TGT_NONE;
        if (strobe) begin
            if (ofs == OFS_CTRL) begin
                a.tgt = TGT_CTRL;
            end else if (upper && ofs >= UPPER_BASE) begin
                case (ofs)
                    OFS_EXT:    a.tgt = TGT_EXT;
                    OFS_PTR_LO: a.tgt = TGT_PTR_LO;
                    OFS_PTR_HI: a.tgt = TGT_PTR_HI;
                    OFS_PORT:   a.tgt = TGT_PORT;
                    default:    a.tgt = TGT_NONE;
                endcase
            end
        end
        return a;
    endfunction

endpackage

// File: rtl/xram_decode.sv
module xram_decode
    import xram_pkg::*;
(
    input  logic              sel,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              bank_up,
    output access_t           acc
);
    always_comb begin
        acc = decode_access(sel, wr_en, reg_addr, bank_up);
    end
endmodule

// File: rtl/xram_ctl.sv
module xram_ctl
    import xram_pkg::*;
#(
    parameter int unsigned AW = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  access_t           acc,
    input  logic [DATA_W-1:0] wr_data,
    output logic              bank_q,
    output logic              burst_q,
    output logic [AW-1:0]     ptr_q,
    output logic              port_wr
);
    logic [PTR_MAXW-1:0] ptr_wide;
    logic [PTR_MAXW-1:0] lo_merge;
    logic [PTR_MAXW-1:0] hi_merge;
    logic                port_hit;

    always_comb begin
        ptr_wide = PTR_MAXW'(ptr_q);
        lo_merge = {ptr_wide[15:8], wr_data};
        hi_merge = {wr_data, ptr_wide[7:0]};
        port_hit = (acc.tgt == TGT_PORT) && (acc.rd || acc.wr);
        port_wr  = (acc.tgt == TGT_PORT) && acc.wr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q  <= 1'b0;
            burst_q <= 1'b0;
            ptr_q   <= '0;
        end else begin
            if (acc.wr && acc.tgt == TGT_CTRL)   bank_q  <= wr_data[BANK_BIT];
            if (acc.wr && acc.tgt == TGT_EXT)    burst_q <= wr_data[BURST_BIT];
            if (acc.wr && acc.tgt == TGT_PTR_LO) ptr_q   <= lo_merge[AW-1:0];
            if (acc.wr && acc.tgt == TGT_PTR_HI) ptr_q   <= hi_merge[AW-1:0];
            if (port_hit && burst_q)             ptr_q   <= ptr_q + 1'b1;
        end
    end
endmodule

// File: rtl/xram_store.sv
module xram_store
    import xram_pkg::*;
#(
    parameter int unsigned DEPTH = 128,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    assign q = cells[addr];
endmodule

// File: rtl/xram_window.sv
module xram_window
    import xram_pkg::*;
#(
    parameter int unsigned DEPTH = 128
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sel,
    input  logic        wr_en,
    input  logic [6:0]  reg_addr,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data
);
    localparam int unsigned AW = $clog2(DEPTH);

    access_t             acc;
    logic                bank_q;
    logic                burst_q;
    logic [AW-1:0]       ptr_q;
    logic                port_wr;
    logic [DATA_W-1:0]   mem_q;
    logic [PTR_MAXW-1:0] ptr_wide;
    logic [DATA_W-1:0]   rd_mux;
    logic [DATA_W-1:0]   rd_q;

    xram_decode u_decode (
        .sel      (sel),
        .wr_en    (wr_en),
        .reg_addr (reg_addr),
        .bank_up  (bank_q),
        .acc      (acc)
    );

    xram_ctl #(.AW(AW)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .wr_data (wr_data),
        .bank_q  (bank_q),
        .burst_q (burst_q),
        .ptr_q   (ptr_q),
        .port_wr (port_wr)
    );

    xram_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (port_wr),
        .addr  (ptr_q),
        .wdata (wr_data),
        .q     (mem_q)
    );

    always_comb begin
        ptr_wide = PTR_MAXW'(ptr_q);
        rd_mux   = '0;
        case (acc.tgt)
            TGT_CTRL:   rd_mux[BANK_BIT]  = bank_q;
            TGT_EXT:    rd_mux[BURST_BIT] = burst_q;
            TGT_PTR_LO: rd_mux = ptr_wide[7:0];
            TGT_PTR_HI: rd_mux = ptr_wide[15:8];
            TGT_PORT:   rd_mux = mem_q;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rd_q <= '0;
        else if (acc.rd) rd_q <= rd_mux;
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/xram_window_chk.sv
module xram_window_chk
    import xram_pkg::*;
#(
    parameter int unsigned AW = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          sel,
    input logic          wr_en,
    input logic [6:0]    reg_addr,
    input logic [7:0]    wr_data,
    input logic [7:0]    rd_data,
    input logic          bank_q,
    input logic          burst_q,
    input logic [AW-1:0] ptr_q
);
    logic port_acc;
    assign port_acc = sel && bank_q && (reg_addr == OFS_PORT);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (rd_data == 8'h00 && !bank_q && !burst_q && ptr_q == '0));

    assert_bank_write_R2: assert property (@(posedge clk) disable iff (rst)
        (sel && wr_en && reg_addr == OFS_CTRL) |=> (bank_q == $past(wr_data[BANK_BIT])));

    assert_lower_bank_inert_R3: assert property (@(posedge clk) disable iff (rst)
        (sel && wr_en && !bank_q && reg_addr >= UPPER_BASE) |=> ($stable(ptr_q) && $stable(burst_q)));

    assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !(sel && !wr_en) |=> $stable(rd_data));

    assert_burst_step_R6: assert property (@(posedge clk) disable iff (rst)
        (port_acc && burst_q) |=> (ptr_q == AW'($past(ptr_q) + 1'b1)));

    assert_no_burst_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (port_acc && !burst_q) |=> $stable(ptr_q));

    assert_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (port_acc && burst_q && (&ptr_q)) |=> (ptr_q == '0));
endmodule

bind xram_window xram_window_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .wr_en    (wr_en),
    .reg_addr (reg_addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .bank_q   (bank_q),
    .burst_q  (burst_q),
    .ptr_q    (ptr_q)
);

// File: tb/xram_window_bench.sv
module xram_window_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel0 = 1'b0;
    logic       sel1 = 1'b0;
    logic       wr_en = 1'b0;
    logic [6:0] reg_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd0;
    logic [7:0] rd1;
    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    xram_window #(.DEPTH(128)) u_xram_window (
        .clk(clk), .rst(rst), .sel(sel0), .wr_en(wr_en),
        .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd0)
    );

    xram_window #(.DEPTH(2048)) u_xram_window_big (
        .clk(clk), .rst(rst), .sel(sel1), .wr_en(wr_en),
        .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd1)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int s, input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        sel0 = (s == 0); sel1 = (s == 1); wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        sel0 = 1'b0; sel1 = 1'b0; wr_en = 1'b0;
    endtask

    task automatic rd(input int s, input logic [6:0] a, output logic [7:0] v);
        @(negedge clk);
        sel0 = (s == 0); sel1 = (s == 1); wr_en = 1'b0; reg_addr = a;
        @(negedge clk);
        sel0 = 1'b0; sel1 = 1'b0;
        v = (s == 1) ? rd1 : rd0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] hold;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        check("R1 rd_data", rd0, 8'h00);
        rd(0, 7'h0A, v); check("R1 ctrl", v, 8'h00);
        // R3: lower bank hides the upper offsets
        rd(0, 7'h50, v); check("R3 lo hidden", v, 8'h00);
        wr(0, 7'h50, 8'h33);
        wr(0, 7'h4A, 8'hFF);
        // R2: bank select
        wr(0, 7'h0A, 8'hFF);
        rd(0, 7'h0A, v); check("R2 bank bit only", v, 8'h10);
        rd(0, 7'h50, v); check("R3 write ignored ptr", v, 8'h00);
        rd(0, 7'h4A, v); check("R3 write ignored burst", v, 8'h00);
        rd(0, 7'h51, v); check("R1 ptr hi", v, 8'h00);

        // R4: masking for DEPTH=128
        wr(0, 7'h50, 8'hFF);
        rd(0, 7'h50, v); check("R4 lo masked", v, 8'h7F);
        wr(0, 7'h51, 8'hAB);
        rd(0, 7'h51, v); check("R4 hi masked", v, 8'h00);

        // R5/R7: full sweep, non-burst
        for (int i = 0; i < 128; i++) begin
            wr(0, 7'h50, 8'(i));
            wr(0, 7'h53, pat(i));
            rd(0, 7'h50, v); check("R7 ptr after write", v, 8'(i));
        end
        for (int i = 0; i < 128; i++) begin
            wr(0, 7'h50, 8'(i));
            rd(0, 7'h53, v); check("R5 readback", v, pat(i));
            rd(0, 7'h50, v); check("R7 ptr after read", v, 8'(i));
        end

        // R5: rd_data holds across writes and idle cycles
        hold = rd0;
        wr(0, 7'h53, 8'h00);
        wr(0, 7'h53, pat(127));
        repeat (3) @(negedge clk);
        check("R5 hold", rd0, hold);

        // R6/R8: burst reads across the wrap
        wr(0, 7'h4A, 8'hFF);
        rd(0, 7'h4A, v); check("R6 burst bit only", v, 8'h20);
        wr(0, 7'h50, 8'h7E);
        for (int k = 0; k < 4; k++) begin
            rd(0, 7'h53, v); check("R8 burst read", v, pat((126 + k) % 128));
        end
        rd(0, 7'h50, v); check("R6 ptr advanced", v, 8'h02);

        // R6: burst writes
        wr(0, 7'h50, 8'h10);
        for (int k = 0; k < 8; k++) wr(0, 7'h53, 8'(8'hC0 + k));
        rd(0, 7'h50, v); check("R6 ptr after burst writes", v, 8'h18);
        wr(0, 7'h50, 8'h10);
        for (int k = 0; k < 8; k++) begin
            rd(0, 7'h53, v); check("R6 burst write data", v, 8'(8'hC0 + k));
        end

        // R7: burst off again
        wr(0, 7'h4A, 8'h00);
        wr(0, 7'h50, 8'h12);
        rd(0, 7'h53, v); check("R7 data", v, 8'hC2);
        rd(0, 7'h53, v); check("R7 same byte", v, 8'hC2);
        rd(0, 7'h50, v); check("R7 ptr still", v, 8'h12);

        // R9: unmapped offsets
        wr(0, 7'h20, 8'h55);
        rd(0, 7'h20, v); check("R9 unmapped low", v, 8'h00);
        wr(0, 7'h52, 8'h77);
        rd(0, 7'h52, v); check("R9 unmapped upper", v, 8'h00);
        rd(0, 7'h50, v); check("R9 ptr untouched", v, 8'h12);

        // Second copy, DEPTH=2048
        wr(1, 7'h0A, 8'h10);
        wr(1, 7'h51, 8'hFF);
        rd(1, 7'h51, v); check("R4 hi masked 2048", v, 8'h07);
        wr(1, 7'h50, 8'hFE);
        wr(1, 7'h4A, 8'h20);
        wr(1, 7'h53, 8'hA1);
        wr(1, 7'h53, 8'hB2);
        wr(1, 7'h53, 8'hC3);
        rd(1, 7'h50, v); check("R8 wrap lo 2048", v, 8'h01);
        rd(1, 7'h51, v); check("R8 wrap hi 2048", v, 8'h00);
        wr(1, 7'h4A, 8'h00);
        wr(1, 7'h51, 8'h01);
        wr(1, 7'h50, 8'h00);
        wr(1, 7'h53, 8'hD4);
        wr(1, 7'h51, 8'h00);
        rd(1, 7'h53, v); check("R4 0x000 distinct from 0x100", v, 8'hC3);
        wr(1, 7'h51, 8'h00);
        wr(1, 7'h50, 8'hFF);
        wr(1, 7'h4A, 8'h20);
        wr(1, 7'h53, 8'hE5);
        rd(1, 7'h51, v); check("R6 carry into hi", v, 8'h01);
        rd(1, 7'h50, v); check("R6 carry lo", v, 8'h00);
        rd(1, 7'h53, v); check("R5 0x100 data", v, 8'hD4);
        wr(1, 7'h51, 8'h07);
        wr(1, 7'h50, 8'hFE);
        rd(1, 7'h53, v); check("R8 read 0x7FE", v, 8'hA1);
        rd(1, 7'h53, v); check("R8 read 0x7FF", v, 8'hB2);
        rd(1, 7'h53, v); check("R8 read 0x000", v, 8'hC3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule